// File: doc/BRIEF.md
# I2C Target Front End with Strap-Selected Address

This block is the bus-facing half of a register-based peripheral. It samples the two-wire serial clock and data lines with the system clock, finds bus conditions, and decides whether a transfer is meant for this device. The bus address is one of three 7-bit values. A 2-bit strap input picks it, and that input stands for how a board ties an address pin: low, high, or to the data line.

After a matching address the block acknowledges and moves bytes between the bus and a byte-wide register port. In a write, the first data byte sets an internal register pointer. Each later byte goes out on a one-cycle write strobe, with the pointer as the register index. In a read, the block takes a byte from the read-data input for the current pointer and shifts it out. The master's acknowledge bit then decides whether another byte follows. The pointer steps by one after every byte written or read, and it keeps its value across transactions. A write that only sets the pointer, followed by a repeated START and a read, therefore reads from that pointer.

The data output is an open-drain enable: when it is high the line is pulled low. Clock stretching, 10-bit addressing and the general call are not supported.

Top module: `i2c_strap_target`

## Requirements
- R1: After reset, sda_oe, reg_wr and reg_rd are 0 and reg_addr is 0. Both bus lines idle high. A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high.
- R2: The strap picks the device address: strap_sel 2'b00 gives 7'h10, 2'b01 gives 7'h11, 2'b10 gives 7'h13, and 2'b11 is treated like 2'b00. The first byte after a START is the address, MSB first, followed by a direction bit. On a match the block holds SDA low for the whole ninth clock.
- R3: On an address mismatch the block never pulls SDA and gives no strobe until the next START or STOP.
- R4: A direction bit of 0 selects a write and 1 selects a read.
- R5: In a write, the first data byte loads the 8-bit pointer. Each later byte gives a one-cycle reg_wr with reg_wdata equal to the byte and reg_addr equal to the pointer, and the pointer then steps by one, wrapping from 8'hFF to 8'h00. Every data byte is acknowledged.
- R6: In a read, each byte is taken from reg_rdata, which must show the register at reg_addr, in a cycle that pulses reg_rd. The byte is sent MSB first and the pointer then steps by one. A master ACK (SDA low on the ninth clock) starts another byte. A master NACK makes the block release SDA until the next START or STOP.
- R7: A repeated START restarts address reception and keeps the pointer.
- R8: A STOP at any bit position ends the transfer. A partly received byte is discarded and the pointer is kept.
- R9: A STOP in the same SCL high phase as the START before it is ignored, and the transfer goes on.
- R10: sda_oe changes only in response to a cycle in which the synchronised SCL is low.
- R11: reg_wr and reg_rd are single-cycle pulses and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| strap_sel | input | 2 | Address strap: 00 low, 01 high, 10 data line, 11 as 00 |
| scl_in | input | 1 | Serial clock line as seen at the pin |
| sda_in | input | 1 | Serial data line as seen at the pin |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| reg_addr | output | 8 | Register pointer |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_wdata | output | 8 | Byte to write, valid with reg_wr |
| reg_rd | output | 1 | One-cycle pulse when a read byte is captured |
| reg_rdata | input | 8 | Register contents at reg_addr |

## Verification
The bench sweeps every strap value against matching and non-matching address probes. A wrong decode, or 2'b11 not falling back to the low address, shows up as a missing or extra acknowledge. A STOP placed in the same SCL high phase as the START must leave the address byte acknowledged; a design that honours that STOP would go idle and not acknowledge. A STOP in mid-byte followed by a read must return the register at the kept pointer without any write; a design that keeps its bit count, or commits the partial byte, gives a wrong strobe or wrong data. The read path is checked across a repeated START, with a NACK at the end, and with clock pulses after the NACK that must read all ones. Pointer wrap from 8'hFF is checked on the write path.

// File: rtl/i2c_tgt_pkg.sv
// Package: shared state encoding and strap address values for the I2C target.
// Assumes: 7-bit addressing only.
package i2c_tgt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_ADDR = 3'd1,
        ST_AACK = 3'd2,
        ST_WRX  = 3'd3,
        ST_WACK = 3'd4,
        ST_RDX  = 3'd5,
        ST_RACK = 3'd6,
        ST_SKIP = 3'd7
    } tgt_state_e;

    localparam logic [6:0] DEV_ADDR_LOW  = 7'h10;
    localparam logic [6:0] DEV_ADDR_HIGH = 7'h11;
    localparam logic [6:0] DEV_ADDR_DATA = 7'h13;

    localparam logic [1:0] STRAP_LOW  = 2'b00;
    localparam logic [1:0] STRAP_HIGH = 2'b01;
    localparam logic [1:0] STRAP_DATA = 2'b10;

endpackage

// File: rtl/i2c_line_monitor.sv
// Module: i2c_line_monitor
// Synchronises SCL and SDA into the clk domain and reports SCL edges, START
// and STOP. A STOP in the same SCL high phase as a START is suppressed.
// Assumes: clk is at least several times faster than SCL; SYNC_STAGES >= 2.
module i2c_line_monitor #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [LAST:0] scl_ff;
    logic [LAST:0] sda_ff;
    logic          scl_q;
    logic          sda_q;
    logic          start_hi;
    logic          stop_raw;

    // Synchroniser chains; stage 0 takes the pin, one stage per generate step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_ff[0] <= 1'b1;
            sda_ff[0] <= 1'b1;
        end else begin
            scl_ff[0] <= scl_in;
            sda_ff[0] <= sda_in;
        end
    end

    for (genvar g = 1; g < SYNC_STAGES; g++) begin : g_sync
        // One further synchroniser stage.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                scl_ff[g] <= 1'b1;
                sda_ff[g] <= 1'b1;
            end else begin
                scl_ff[g] <= scl_ff[g-1];
                sda_ff[g] <= sda_ff[g-1];
            end
        end
    end

    assign scl_s = scl_ff[LAST];
    assign sda_s = sda_ff[LAST];

    // Previous synchronised sample, for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign start_det = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_raw  = scl_s & scl_q & ~sda_q & sda_s;

    // Marks the SCL high phase that carried a START.
    always_ff @(posedge clk) begin
        if (!rst_n)
            start_hi <= 1'b0;
        else if (start_det)
            start_hi <= 1'b1;
        else if (scl_fall)
            start_hi <= 1'b0;
    end

    assign stop_det = stop_raw & ~start_hi;

endmodule

// File: rtl/i2c_strap_addr.sv
// Module: i2c_strap_addr
// Decodes the 2-bit strap into the 7-bit device address. The unused code
// falls back to the low-strap address.
// Assumes: strap_sel is static during a transfer.
module i2c_strap_addr
    import i2c_tgt_pkg::*;
(
    input  logic [1:0] strap_sel,
    output logic [6:0] dev_addr
);
    // Strap to address lookup.
    always_comb begin
        case (strap_sel)
            STRAP_HIGH: dev_addr = DEV_ADDR_HIGH;
            STRAP_DATA: dev_addr = DEV_ADDR_DATA;
            STRAP_LOW:  dev_addr = DEV_ADDR_LOW;
            default:    dev_addr = DEV_ADDR_LOW;
        endcase
    end
endmodule

// File: rtl/i2c_byte_engine.sv
// Module: i2c_byte_engine
// Bit/byte sequencer: address match, ACK drive, write and read byte transfer,
// register pointer. All SDA drive changes are made on SCL falling edges.
// Assumes: reg_rdata reflects reg_addr combinationally.
module i2c_byte_engine
    import i2c_tgt_pkg::*;
#(
    parameter int PTR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             sda_s,
    input  logic             start_det,
    input  logic             stop_det,
    input  logic [6:0]       dev_addr,
    input  logic [7:0]       reg_rdata,
    output logic             sda_oe,
    output logic             reg_wr,
    output logic [7:0]       reg_wdata,
    output logic             reg_rd,
    output logic [PTR_W-1:0] reg_addr
);
    localparam int BITS = 8;
    localparam int CW   = $clog2(BITS);
    localparam logic [CW-1:0] LAST_BIT = CW'(BITS - 1);

    tgt_state_e      state;
    logic [CW-1:0]   cnt;
    logic [6:0]      sr;
    logic [6:0]      tx;
    logic            ackph;
    logic            rw_q;
    logic            need_ptr;
    logic            more;
    logic [PTR_W-1:0] ptr;
    logic [7:0]      rx_byte;

    // Byte assembled from the shift register and the current bit.
    always_comb rx_byte = {sr, sda_s};

    assign reg_addr = ptr;

    // Main sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            sr        <= '0;
            tx        <= '0;
            ackph     <= 1'b0;
            rw_q      <= 1'b0;
            need_ptr  <= 1'b0;
            more      <= 1'b0;
            ptr       <= '0;
            sda_oe    <= 1'b0;
            reg_wr    <= 1'b0;
            reg_wdata <= '0;
            reg_rd    <= 1'b0;
        end else begin
            reg_wr <= 1'b0;
            reg_rd <= 1'b0;
            if (reg_wr || reg_rd)
                ptr <= ptr + PTR_W'(1);
            if (start_det) begin
                state  <= ST_ADDR;
                cnt    <= '0;
                ackph  <= 1'b0;
                sda_oe <= 1'b0;
            end else if (stop_det) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR: if (scl_rise) begin
                        sr  <= rx_byte[6:0];
                        cnt <= cnt + CW'(1);
                        if (cnt == LAST_BIT) begin
                            if (rx_byte[7:1] == dev_addr) begin
                                state    <= ST_AACK;
                                rw_q     <= rx_byte[0];
                                need_ptr <= ~rx_byte[0];
                                ackph    <= 1'b0;
                            end else begin
                                state <= ST_SKIP;
                            end
                        end
                    end
                    ST_AACK: if (scl_fall) begin
                        if (!ackph) begin
                            sda_oe <= 1'b1;
                            ackph  <= 1'b1;
                        end else begin
                            ackph <= 1'b0;
                            cnt   <= '0;
                            if (rw_q) begin
                                tx     <= reg_rdata[6:0];
                                sda_oe <= ~reg_rdata[7];
                                reg_rd <= 1'b1;
                                state  <= ST_RDX;
                            end else begin
                                sda_oe <= 1'b0;
                                state  <= ST_WRX;
                            end
                        end
                    end
                    ST_WRX: if (scl_rise) begin
                        sr  <= rx_byte[6:0];
                        cnt <= cnt + CW'(1);
                        if (cnt == LAST_BIT) begin
                            if (need_ptr) begin
                                ptr      <= PTR_W'(rx_byte);
                                need_ptr <= 1'b0;
                            end else begin
                                reg_wr    <= 1'b1;
                                reg_wdata <= rx_byte;
                            end
                            ackph <= 1'b0;
                            state <= ST_WACK;
                        end
                    end
                    ST_WACK: if (scl_fall) begin
                        if (!ackph) begin
                            sda_oe <= 1'b1;
                            ackph  <= 1'b1;
                        end else begin
                            ackph  <= 1'b0;
                            sda_oe <= 1'b0;
                            cnt    <= '0;
                            state  <= ST_WRX;
                        end
                    end
                    ST_RDX: if (scl_fall) begin
                        if (cnt == LAST_BIT) begin
                            sda_oe <= 1'b0;
                            state  <= ST_RACK;
                        end else begin
                            sda_oe <= ~tx[6];
                            tx     <= {tx[5:0], 1'b0};
                            cnt    <= cnt + CW'(1);
                        end
                    end
                    ST_RACK: begin
                        if (scl_rise)
                            more <= ~sda_s;
                        if (scl_fall) begin
                            if (more) begin
                                tx     <= reg_rdata[6:0];
                                sda_oe <= ~reg_rdata[7];
                                reg_rd <= 1'b1;
                                cnt    <= '0;
                                state  <= ST_RDX;
                            end else begin
                                state <= ST_SKIP;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/i2c_strap_target.sv
// Module: i2c_strap_target (top)
// I2C target front end: line monitor, strap address decode and byte engine.
// Assumes: no clock stretching; SDA output is open drain via sda_oe.
module i2c_strap_target #(
    parameter int PTR_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       strap_sel,
    input  logic             scl_in,
    input  logic             sda_in,
    output logic             sda_oe,
    output logic [PTR_W-1:0] reg_addr,
    output logic             reg_wr,
    output logic [7:0]       reg_wdata,
    output logic             reg_rd,
    input  logic [7:0]       reg_rdata
);
    logic       scl_sync;
    logic       sda_sync;
    logic       scl_rise;
    logic       scl_fall;
    logic       start_det;
    logic       stop_det;
    logic [6:0] dev_addr;

    i2c_line_monitor #(.SYNC_STAGES(SYNC_STAGES)) u_mon (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .scl_s     (scl_sync),
        .sda_s     (sda_sync),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_strap_addr u_strap (
        .strap_sel (strap_sel),
        .dev_addr  (dev_addr)
    );

    i2c_byte_engine #(.PTR_W(PTR_W)) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .sda_s     (sda_sync),
        .start_det (start_det),
        .stop_det  (stop_det),
        .dev_addr  (dev_addr),
        .reg_rdata (reg_rdata),
        .sda_oe    (sda_oe),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr)
    );

endmodule

// File: rtl/i2c_strap_target_chk.sv
// Module: i2c_strap_target_chk
// Temporal checks on the target's outputs, bound into the top module.
// Assumes: scl_s is the synchronised SCL used by the engine.
module i2c_strap_target_chk #(
    parameter int PTR_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             scl_s,
    input logic             sda_oe,
    input logic             reg_wr,
    input logic             reg_rd,
    input logic [PTR_W-1:0] reg_addr
);
    // R10: drive changes are decided while SCL is low
    p_oe_scl_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !$past(scl_s));

    // R11: write strobe lasts one cycle
    p_wr_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> !reg_wr);

    // R11: read request lasts one cycle
    p_rd_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |=> !reg_rd);

    // R11: never both strobes at once
    p_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_rd));

    // R5: pointer steps after a write
    p_ptr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> reg_addr == PTR_W'($past(reg_addr) + PTR_W'(1)));

    // R6: pointer steps after a read capture
    p_ptr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |=> reg_addr == PTR_W'($past(reg_addr) + PTR_W'(1)));

endmodule

bind i2c_strap_target i2c_strap_target_chk #(.PTR_W(PTR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_s    (scl_sync),
    .sda_oe   (sda_oe),
    .reg_wr   (reg_wr),
    .reg_rd   (reg_rd),
    .reg_addr (reg_addr)
);

// File: tb/i2c_strap_target_test.sv
module i2c_strap_target_test;
    localparam int Q = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] strap_sel = 2'b00;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_oe;
    logic [7:0] reg_addr;
    logic       reg_wr;
    logic [7:0] reg_wdata;
    logic       reg_rd;
    logic [7:0] reg_rdata;
    wire        sda_line = sda_m & ~sda_oe;

    int total = 0;
    int bad = 0;
    int wr_n = 0;
    int rd_n = 0;
    logic [7:0] mem [0:255];
    logic [7:0] wr_a [0:31];
    logic [7:0] wr_d [0:31];
    bit done = 1'b0;

    always #10 clk = ~clk;

    i2c_strap_target uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .strap_sel (strap_sel),
        .scl_in    (scl_m),
        .sda_in    (sda_line),
        .sda_oe    (sda_oe),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rd    (reg_rd),
        .reg_rdata (reg_rdata)
    );

    // Register file model behind the port.
    assign reg_rdata = mem[reg_addr];
    always @(posedge clk) begin
        if (reg_wr) begin
            mem[reg_addr] <= reg_wdata;
            wr_a[wr_n % 32] <= reg_addr;
            wr_d[wr_n % 32] <= reg_wdata;
            wr_n <= wr_n + 1;
        end
        if (reg_rd)
            rd_n <= rd_n + 1;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic m_start();
        sda_m = 1'b1; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b0; wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic m_stop();
        sda_m = 1'b0; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b1; wq();
    endtask

    task automatic m_bit(input bit b);
        sda_m = b; wq();
        scl_m = 1'b1; wq(); wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic m_send(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) m_bit(b[i]);
        sda_m = 1'b1; wq();
        scl_m = 1'b1; wq();
        ack = (sda_line == 1'b0);
        wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic m_read(input bit mack, output logic [7:0] v);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wq();
            scl_m = 1'b1; wq();
            v[i] = sda_line;
            wq();
            scl_m = 1'b0;
        end
        sda_m = mack ? 1'b0 : 1'b1; wq();
        scl_m = 1'b1; wq(); wq();
        scl_m = 1'b0; wq();
        sda_m = 1'b1;
    endtask

    task automatic finish_up();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // Watchdog.
    initial begin
        repeat (200000) @(negedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=0 expected=1");
            finish_up();
        end
    end

    initial begin
        bit ack;
        logic [7:0] v;
        int w0;
        int r0;
        logic [6:0] probes [0:7];
        logic [6:0] expa;
        probes[0] = 7'h10; probes[1] = 7'h11; probes[2] = 7'h13; probes[3] = 7'h12;
        probes[4] = 7'h00; probes[5] = 7'h7F; probes[6] = 7'h50; probes[7] = 7'h30;
        for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h5A;

        repeat (5) @(negedge clk);
        // R1: reset state
        chk(sda_oe == 1'b0, "R1 sda_oe reset", sda_oe, 0);
        chk(reg_wr == 1'b0, "R1 reg_wr reset", reg_wr, 0);
        chk(reg_rd == 1'b0, "R1 reg_rd reset", reg_rd, 0);
        chk(reg_addr == 8'h00, "R1 reg_addr reset", reg_addr, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R2/R4: strap sweep with write-direction probes
        for (int s = 0; s < 4; s++) begin
            strap_sel = 2'(s);
            expa = (s == 1) ? 7'h11 : (s == 2) ? 7'h13 : 7'h10;
            for (int p = 0; p < 8; p++) begin
                m_start();
                m_send({probes[p], 1'b0}, ack);
                m_stop();
                chk(ack == (probes[p] == expa), "R2 address ack", ack, (probes[p] == expa));
            end
        end
        strap_sel = 2'b00;

        // R3: mismatch ignores following bytes
        w0 = wr_n;
        m_start();
        m_send(8'h22, ack); chk(ack == 1'b0, "R3 mismatch addr", ack, 0);
        m_send(8'h05, ack); chk(ack == 1'b0, "R3 mismatch byte1", ack, 0);
        m_send(8'h07, ack); chk(ack == 1'b0, "R3 mismatch byte2", ack, 0);
        m_stop();
        chk(wr_n == w0, "R3 no write strobe", wr_n - w0, 0);

        // R5: pointer then three writes
        w0 = wr_n;
        m_start();
        m_send(8'h20, ack); chk(ack, "R5 addr ack", ack, 1);
        m_send(8'h20, ack); chk(ack, "R5 pointer ack", ack, 1);
        m_send(8'hA1, ack); chk(ack, "R5 data ack", ack, 1);
        m_send(8'hB2, ack);
        m_send(8'hC3, ack);
        m_stop();
        chk(wr_n - w0 == 3, "R5 write count", wr_n - w0, 3);
        for (int k = 0; k < 3; k++) begin
            chk(wr_a[(w0 + k) % 32] == 8'(8'h20 + k), "R5 write addr", wr_a[(w0 + k) % 32], 8'h20 + k);
            chk(wr_d[(w0 + k) % 32] == 8'(8'hA1 + 8'h11 * k), "R5 write data", wr_d[(w0 + k) % 32], 8'hA1 + 8'h11 * k);
        end

        // R5: pointer wraps
        w0 = wr_n;
        m_start();
        m_send(8'h20, ack); m_send(8'hFF, ack);
        m_send(8'h3C, ack); m_send(8'h4D, ack);
        m_stop();
        chk(wr_a[w0 % 32] == 8'hFF, "R5 wrap first", wr_a[w0 % 32], 8'hFF);
        chk(wr_a[(w0 + 1) % 32] == 8'h00, "R5 wrap second", wr_a[(w0 + 1) % 32], 0);

        // R7/R6: set pointer, repeated START, read three bytes
        r0 = rd_n;
        m_start();
        m_send(8'h20, ack); m_send(8'h20, ack);
        m_start();
        m_send(8'h21, ack); chk(ack, "R7 read addr ack after Sr", ack, 1);
        m_read(1'b1, v); chk(v == 8'hA1, "R6 read byte0", v, 8'hA1);
        m_read(1'b1, v); chk(v == 8'hB2, "R6 read byte1", v, 8'hB2);
        m_read(1'b0, v); chk(v == 8'hC3, "R6 read byte2", v, 8'hC3);
        repeat (4) @(negedge clk);
        chk(sda_oe == 1'b0, "R6 released after NACK", sda_oe, 0);
        m_read(1'b0, v); chk(v == 8'hFF, "R6 idle after NACK", v, 8'hFF);
        chk(rd_n - r0 == 3, "R6 read count", rd_n - r0, 3);
        m_stop();

        // R8: STOP mid-byte discards the partial byte, keeps pointer
        w0 = wr_n;
        m_start();
        m_send(8'h20, ack); m_send(8'h30, ack);
        m_bit(1'b1); m_bit(1'b1); m_bit(1'b0); m_bit(1'b1);
        m_stop();
        chk(wr_n == w0, "R8 no write on abort", wr_n - w0, 0);
        m_start();
        m_send(8'h21, ack);
        m_read(1'b0, v);
        m_stop();
        chk(v == (8'h30 ^ 8'h5A), "R8 pointer kept", v, 8'h30 ^ 8'h5A);
        m_start();
        m_send(8'h20, ack); m_send(8'h50, ack); m_send(8'h77, ack);
        m_stop();
        chk(wr_a[w0 % 32] == 8'h50 && wr_d[w0 % 32] == 8'h77, "R8 clean restart", wr_d[w0 % 32], 8'h77);

        // R9: STOP in the START's high phase is ignored
        w0 = wr_n;
        sda_m = 1'b1; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b0; wq();
        sda_m = 1'b1; wq();
        scl_m = 1'b0; wq();
        m_send(8'h20, ack); chk(ack, "R9 ack after ignored stop", ack, 1);
        m_send(8'h60, ack); m_send(8'h99, ack);
        m_stop();
        chk(wr_n - w0 == 1 && wr_a[w0 % 32] == 8'h60 && wr_d[w0 % 32] == 8'h99,
            "R9 write after ignored stop", wr_d[w0 % 32], 8'h99);

        // R4: read direction on strap 2'b11 (falls back to 7'h10)
        strap_sel = 2'b11;
        m_start();
        m_send(8'h21, ack); chk(ack, "R4 read select ack", ack, 1);
        m_read(1'b0, v);
        m_stop();
        chk(v == mem[8'h61], "R4 read data", v, mem[8'h61]);

        done = 1'b1;
        finish_up();
    end
endmodule